// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This unit keeps the protection state of a serial non-volatile memory and rules on every write request. It holds a write-enable latch, a two-bit block-protect level and a protect-enable bit, and it watches an active-low write-protect pin and the chip-select line. A memory write brings its target address, and a status write brings its new byte. For each one the unit answers allow or deny one cycle later. An allowed write waits for chip select to rise and then runs an internal write cycle of fixed length. The stored bits change only when that cycle completes.

The 8-bit status byte is presented at all times for reads. The serial shifter ahead of the unit decodes commands and hands each one over as a single-cycle request. The array and the timing of the real storage cells are outside this unit.

Top module: `wp_guard`

## Requirements
- R1: After reset the status byte reads 0x00: the latch is clear, the protect level is 00, the protect-enable bit is 0, and no cycle is running.
- R2: Command codes on `cmd_op` are 1 = set latch, 2 = clear latch, 3 = memory write, 4 = status write, and 0 = none. Set-latch makes status bit 1 read 1. Clear-latch makes it read 0 whatever the level of `wp_n`. Both are allowed whenever the unit is idle.
- R3: While the latch is clear, memory writes and status writes are denied, and raising `cs_n` afterwards starts no cycle: status bit 0 stays 0.
- R4: Status bits 3:2 hold the protect level. 00 protects no address. 01 protects addresses whose two top bits are 11. 10 protects addresses whose top bit is 1. 11 protects every address. A memory write to a protected address is denied.
- R5: When `wp_n` is low and status bit 7 is 1, status writes are denied and the status byte is left unchanged. When `wp_n` is low and bit 7 is 0, status writes are allowed.
- R6: An allowed write starts the internal cycle on the first clock that sees `cs_n` high after the request. The status byte then reads 0xFF for exactly WCYC cycles.
- R7: When the cycle completes, the latch clears. After a status write, bit 7 and bits 3:2 take the written byte's bits 7 and 3:2. Its other bits are dropped, and bits 6:4 read 0 when idle.
- R8: During the internal cycle every command is denied and has no effect. A set-latch issued then leaves bit 1 at 0 after the cycle.
- R9: If `wp_n` falls while a status write waits for `cs_n` and bit 7 is 1, the write is cancelled. No cycle starts and the status byte is unchanged. A fall of `wp_n` once the cycle has started does not stop it.
- R10: Each request answers with `rsp_valid` high on the cycle after `cmd_valid`. `rsp_allow` gives the verdict. `rsp_valid` is never high without a request.
- R11: While an allowed write is waiting for `cs_n` to rise, any further command is denied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; its rise launches a waiting write |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_valid | input | 1 | Single-cycle command request |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Target address of a memory write |
| cmd_data | input | 8 | New status byte of a status write |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_allow | output | 1 | 1 = allowed, 0 = denied |
| stat_byte | output | 8 | Status byte for reads |

## Verification
The bench builds the unit with ADDR_W = 8 and WCYC = 6. The narrow address puts the quarter and half boundaries (0xBF/0xC0 and 0x7F/0x80) within a few directed writes. The short cycle lets the exact busy length, the commands issued during it, and a pin fall in mid-cycle all be observed in a few dozen clocks. The protect-pin scenarios cover both settings of the enable bit, a cancel of a waiting status write, and the latch-clear command under a low pin.

// File: rtl/wpg_pkg.sv
// Shared types for the write-protection unit.
// Assumes command codes are fixed by the decoder ahead of the unit.
package wpg_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_SETWE = 3'd1,
        OP_CLRWE = 3'd2,
        OP_MEMWR = 3'd3,
        OP_STWR  = 3'd4
    } wpg_op_e;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_MEM  = 2'd1,
        PEND_STAT = 2'd2
    } wpg_pend_e;

    typedef struct packed {
        logic       lock_en;
        logic [1:0] level;
    } wpg_nv_t;

    localparam logic [7:0] BUSY_BYTE = 8'hFF;

endpackage

// File: rtl/wpg_region.sv
// Decides whether an address falls inside the block-protected region.
// Assumes ADDR_W >= 2. Level 01 covers the top quarter, 10 the top half,
// and 11 the whole space.
module wpg_region #(
    parameter int unsigned ADDR_W = 14
) (
    input  logic [1:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam int unsigned TOP = ADDR_W - 1;

    logic in_quarter;
    logic in_half;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign in_quarter = addr[TOP] & addr[TOP-1];
            assign in_half    = addr[TOP];
        end else begin : g_narrow
            assign in_quarter = addr[TOP];
            assign in_half    = addr[TOP];
        end
    endgenerate

    // Select the region test for the current level.
    always_comb begin
        unique case (level)
            2'b00:   prot = 1'b0;
            2'b01:   prot = in_quarter;
            2'b10:   prot = in_half;
            default: prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/wpg_pin_sense.sv
// Samples the protect pin. It reports the hardware lock (pin low with the
// enable bit set) and a one-cycle falling-edge flag.
// Assumes wp_n is already synchronous to clk.
module wpg_pin_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic wp_n,
    input  logic lock_en,
    output logic hw_lock,
    output logic wp_fall
);
    logic wp_q;

    // Keep the previous pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wp_q <= 1'b1;
        else        wp_q <= wp_n;
    end

    assign hw_lock = ~wp_n & lock_en;
    assign wp_fall = wp_q & ~wp_n;
endmodule

// File: rtl/wpg_cycle_timer.sv
// Counts the internal write cycle. busy is high for WCYC cycles after
// start. done pulses in the last busy cycle, on the edge that commits.
// Assumes start is never asserted while busy.
module wpg_cycle_timer #(
    parameter int unsigned WCYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(WCYC + 1);

    logic [CW-1:0] cnt;

    // Load on start and count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(WCYC);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
endmodule

// File: rtl/wp_guard.sv
// Write-protection unit: holds the write-enable latch, protect level and
// protect-enable bit, rules on each write request, and runs the internal
// cycle that commits it. Assumes one request per cycle at most and
// requests issued while cs_n is low.
module wp_guard
    import wpg_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned WCYC   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic [7:0]        stat_byte
);
    wpg_op_e   op;
    wpg_pend_e pend;
    wpg_nv_t   nv;
    logic      wen;
    logic      cs_q;
    logic      cs_rise;
    logic      prot;
    logic      hw_lock;
    logic      wp_fall;
    logic      busy;
    logic      done;
    logic      can_take;
    logic      allow;
    logic      cancel;
    logic      start;
    logic      cyc_stat;
    logic [7:0] pend_data;
    logic      pend_any;

    assign op = wpg_op_e'(cmd_op);

    wpg_region #(.ADDR_W(ADDR_W)) u_region (
        .level (nv.level),
        .addr  (cmd_addr),
        .prot  (prot)
    );

    wpg_pin_sense u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .wp_n    (wp_n),
        .lock_en (nv.lock_en),
        .hw_lock (hw_lock),
        .wp_fall (wp_fall)
    );

    wpg_cycle_timer #(.WCYC(WCYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    // Track chip select to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end
    assign cs_rise = cs_n & ~cs_q;

    assign pend_any = (pend != PEND_NONE);

    // Rule on the current request.
    always_comb begin
        can_take = cmd_valid && !busy && !pend_any;
        unique case (op)
            OP_SETWE, OP_CLRWE: allow = can_take;
            OP_MEMWR:           allow = can_take && wen && !prot;
            OP_STWR:            allow = can_take && wen && !hw_lock;
            default:            allow = 1'b0;
        endcase
    end

    assign cancel = (pend == PEND_STAT) && wp_fall && nv.lock_en;
    assign start  = pend_any && cs_rise && !cancel;

    // Register the verdict one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_allow <= allow;
        end
    end

    // Hold an allowed write until chip select rises or the pin cancels it.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pend <= PEND_NONE;
        else if (allow && op == OP_MEMWR) pend <= PEND_MEM;
        else if (allow && op == OP_STWR)  pend <= PEND_STAT;
        else if (cancel || start)         pend <= PEND_NONE;
    end

    // Capture the byte of a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pend_data <= 8'h00;
        else if (allow && op == OP_STWR) pend_data <= cmd_data;
    end

    // Remember which kind of write the running cycle commits.
    always_ff @(posedge clk) begin
        if (!rst_n)     cyc_stat <= 1'b0;
        else if (start) cyc_stat <= (pend == PEND_STAT);
    end

    // Commit the stored protection bits at the end of a status-write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv <= '0;
        end else if (done && cyc_stat) begin
            nv.lock_en <= pend_data[7];
            nv.level   <= pend_data[3:2];
        end
    end

    // Write-enable latch: commands set or clear it, cycle completion clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                        wen <= 1'b0;
        else if (done)                     wen <= 1'b0;
        else if (allow && op == OP_SETWE)  wen <= 1'b1;
        else if (allow && op == OP_CLRWE)  wen <= 1'b0;
    end

    // Present the status byte, all ones while busy.
    assign stat_byte = busy ? BUSY_BYTE
                            : {nv.lock_en, 3'b000, nv.level, wen, 1'b0};
endmodule

// File: rtl/wpg_checker.sv
// Temporal checks on the write-protection unit, attached by bind.
module wpg_checker
    import wpg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wp_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       rsp_valid,
    input logic       rsp_allow,
    input logic [7:0] stat_byte,
    input logic       pend_any
);
    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    // R8
    busy_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && stat_byte[0]) |=> !rsp_allow);

    // R7
    cycle_end_clears_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_byte[0]) |-> !stat_byte[1]);

    // R6
    cycle_after_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_byte[0]) |-> $past(cs_n));

    // R2
    clear_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_CLRWE && !stat_byte[0] && !pend_any)
        |=> !stat_byte[1]);

    // R5
    hw_lock_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_STWR && !wp_n && stat_byte[7] && !stat_byte[0])
        |=> !rsp_allow);

    // R11
    pending_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && pend_any) |=> !rsp_allow);
endmodule

bind wp_guard wpg_checker u_wpg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wp_n      (wp_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .rsp_allow (rsp_allow),
    .stat_byte (stat_byte),
    .pend_any  (pend_any)
);

// File: tb/tb_wp_guard.sv
// Scoreboard bench: the driver queues expected verdicts, the monitor
// compares them as responses appear. Status checks are made directly.
module tb_wp_guard;
    localparam int unsigned AW = 8;
    localparam int unsigned WC = 6;

    localparam logic [2:0] C_SETWE = 3'd1;
    localparam logic [2:0] C_CLRWE = 3'd2;
    localparam logic [2:0] C_MEMWR = 3'd3;
    localparam logic [2:0] C_STWR  = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          wp_n = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = 8'h00;
    logic          rsp_valid;
    logic          rsp_allow;
    logic [7:0]    stat_byte;

    int errors = 0;
    int checks = 0;

    typedef struct {
        bit    exp;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    wp_guard #(.ADDR_W(AW), .WCYC(WC)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wp_n      (wp_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .rsp_valid (rsp_valid),
        .rsp_allow (rsp_allow),
        .stat_byte (stat_byte)
    );

    task automatic check_val(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Monitor: compare every verdict with the head of the queue (R10).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check_val(1, 0, "R10 verdict without request");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check_val(int'(rsp_allow), int'(e.exp), e.tag);
            end
        end
    end

    // Driver: issue one request inside a low chip select; called at a negedge.
    task automatic req(input logic [2:0] op, input logic [7:0] a,
                       input logic [7:0] d, input bit exp, input string tag);
        exp_t e;
        e.exp = exp;
        e.tag = tag;
        exp_q.push_back(e);
        cs_n      = 1'b0;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_data  = d;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic close_frame();
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    // Count busy cycles until idle and compare with the expected length.
    task automatic wait_idle(input int exp_len, input string tag);
        int n = 0;
        while (stat_byte[0] && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check_val(n, exp_len, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val(stat_byte, 8'h00, "R1 reset status");

        // R3: no latch, writes denied and no cycle starts.
        req(C_STWR, 8'h00, 8'h84, 1'b0, "R3 status write without latch");
        req(C_MEMWR, 8'h10, 8'h00, 1'b0, "R3 memory write without latch");
        close_frame();
        check_val(stat_byte, 8'h00, "R3 no cycle started");

        // R2: set latch.
        req(C_SETWE, 8'h00, 8'h00, 1'b1, "R2 set latch allowed");
        close_frame();
        check_val(stat_byte, 8'h02, "R2 latch set");

        // R6/R7: status write 0xF5 -> enable=1, level=01.
        req(C_STWR, 8'h00, 8'hF5, 1'b1, "R7 status write allowed");
        close_frame();
        check_val(stat_byte, 8'hFF, "R6 busy byte");
        wait_idle(WC, "R6 busy length");
        check_val(stat_byte, 8'h84, "R7 committed bits, latch cleared");

        // R4: level 01 protects the top quarter.
        req(C_SETWE, 8'h00, 8'h00, 1'b1, "R2 set latch");
        close_frame();
        req(C_MEMWR, 8'hC0, 8'h00, 1'b0, "R4 quarter boundary protected");
        close_frame();
        req(C_MEMWR, 8'hBF, 8'h00, 1'b1, "R4 below quarter allowed");
        close_frame();
        // R8: set latch during the cycle is denied and has no effect.
        req(C_SETWE, 8'h00, 8'h00, 1'b0, "R8 command during busy denied");
        close_frame();
        wait_idle(WC - 2, "R6 memory cycle remainder");
        check_val(stat_byte, 8'h84, "R8 latch untouched after busy");

        // R5: pin low with enable set locks the status register.
        wp_n = 1'b0;
        req(C_SETWE, 8'h00, 8'h00, 1'b1, "R2 set latch under low pin");
        close_frame();
        req(C_STWR, 8'h00, 8'h00, 1'b0, "R5 locked status write denied");
        close_frame();
        check_val(stat_byte, 8'h86, "R5 status unchanged under lock");
        req(C_CLRWE, 8'h00, 8'h00, 1'b1, "R2 clear latch under low pin");
        close_frame();
        check_val(stat_byte, 8'h84, "R2 latch cleared under low pin");

        // R9: pin fall cancels a waiting status write.
        wp_n = 1'b1;
        req(C_SETWE, 8'h00, 8'h00, 1'b1, "R2 set latch");
        close_frame();
        req(C_STWR, 8'h00, 8'h88, 1'b1, "R9 status write pending");
        wp_n = 1'b0;
        @(negedge clk);
        close_frame();
        check_val(stat_byte, 8'h86, "R9 cancelled write, no cycle");

        // R9: pin fall during the cycle does not stop it.
        wp_n = 1'b1;
        @(negedge clk);
        req(C_STWR, 8'h00, 8'h08, 1'b1, "R9 status write allowed");
        close_frame();
        wp_n = 1'b0;
        wait_idle(WC, "R9 cycle runs to the end");
        check_val(stat_byte, 8'h08, "R9 commit despite pin fall");

        // R5: enable bit 0, pin low: status writes allowed. R4 half level.
        req(C_SETWE, 8'h00, 8'h00, 1'b1, "R2 set latch");
        close_frame();
        req(C_MEMWR, 8'h80, 8'h00, 1'b0, "R4 half boundary protected");
        close_frame();
        req(C_STWR, 8'h00, 8'h0C, 1'b1, "R5 unlocked status write allowed");
        // R11: further command while pending is denied.
        req(C_CLRWE, 8'h00, 8'h00, 1'b0, "R11 command while pending denied");
        close_frame();
        wait_idle(WC, "R6 busy length");
        check_val(stat_byte, 8'h0C, "R5 level 11 committed");

        // R4: level 11 protects everything.
        req(C_SETWE, 8'h00, 8'h00, 1'b1, "R2 set latch");
        close_frame();
        req(C_MEMWR, 8'h00, 8'h00, 1'b0, "R4 full level protects address 0");
        close_frame();
        req(C_STWR, 8'h00, 8'h00, 1'b1, "R4 return to level 00");
        close_frame();
        wait_idle(WC, "R6 busy length");
        req(C_SETWE, 8'h00, 8'h00, 1'b1, "R2 set latch");
        close_frame();
        req(C_MEMWR, 8'hFF, 8'h00, 1'b1, "R4 level 00 top address allowed");
        close_frame();
        wait_idle(WC, "R6 busy length");
        check_val(stat_byte, 8'h00, "R7 latch cleared after memory write");

        repeat (2) @(negedge clk);
        check_val(exp_q.size(), 0, "R10 every request answered");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule